// File: doc/BRIEF.md
# Branch Direction Predictor with Speculative Branch Tracking

This block sits in an instruction front end. For every fetch address it reads a table of two-bit direction counters and a direct-mapped target cache in the same cycle. It returns the address to fetch next: the cached target when the counter says taken and the cache holds a matching entry, or the next sequential word otherwise. When the fetched instruction is a decoded branch, the block gives it a small tag and records the branch address and what was predicted for it. At most four such tags are in flight at once.

The branch execution unit reports each branch back with its tag, the actual direction and the actual target. A report on a live tag trains the counter and the target cache. A correct report releases only that tag. A wrong report releases that tag and every younger one. It then starts a fixed recovery sequence. The sequence names four steps: complete up to the branch, flush and refetch from the corrected address, re-dispatch, and re-execute. The recovery machine has five states. RS_IDLE is the rest state. RS_COMPLETE is held for COMPLETE_CYCLES cycles, then RS_FLUSH, RS_DISPATCH and RS_EXECUTE follow, each for one cycle, and the machine returns to RS_IDLE. From any state, a misprediction report on a live tag moves the machine to RS_COMPLETE.

Top module: `branch_spec_unit`

## Requirements
- R1: After reset, stall is 0, all four recovery step outputs are 0, no tag is live, every counter is weakly not-taken (value 1) and every target cache entry is invalid. As a result, next_addr equals fetch_addr + 4 and pred_taken is 0.
- R2: The direction table has 2048 two-bit saturating counters, indexed by fetch_addr[12:2]. Values 2 and 3 predict taken. A report on a live tag moves the counter of that branch's address one step toward the actual outcome, saturating at 0 and 3.
- R3: The target cache has 256 direct-mapped entries, indexed by address bits [9:2] and tagged with bits [17:10]. It hits only when the entry is valid and its stored tag equals those bits.
- R4: While fetch_valid is 1, pred_taken is 1 exactly when the counter predicts taken and the target cache hits. next_addr is then the cached target; otherwise next_addr is fetch_addr + 4.
- R5: A live report with taken=1 writes the entry for the branch address (valid, tag, actual target). A live report with taken=0 whose branch address hits in the target cache clears that entry's valid bit.
- R6: A branch is given a tag when fetch_valid and br_decoded are 1, stall is 0, no recovery is in progress and no misprediction is reported in the same cycle. The tag given is the lowest free one of 0 to 3 and is shown on alloc_tag in that cycle.
- R7: stall is 1 exactly while four tags are live. While stall is 1 and no report arrives, a further decoded branch receives no tag.
- R8: A report is a misprediction when the predicted direction differs from the actual one, or when both are taken but the targets differ. Any other live report is correct and frees only its own tag.
- R9: A misprediction frees its own tag and every tag given out after it, within one cycle. Tags given out before it stay live.
- R10: After a misprediction the step outputs follow this order: rec_complete for COMPLETE_CYCLES cycles (default 1), then rec_flush for one cycle, then rec_dispatch for one cycle, then rec_execute for one cycle. At most one step output is 1 in any cycle. While rec_flush is 1, redirect_addr is the actual target for a taken branch, or the branch address + 4 for a not-taken one.
- R11: A report whose tag is not live is ignored: the tables keep their state, no tag is freed and no recovery starts.
- R12: A misprediction reported during recovery restarts the sequence at rec_complete with the new corrected address. No tag is given out while recovery is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | fetch_addr is valid this cycle |
| fetch_addr | input | 32 | Address being fetched |
| br_decoded | input | 1 | The instruction at fetch_addr is a branch |
| res_valid | input | 1 | A branch report is present |
| res_tag | input | 2 | Tag of the reported branch |
| res_taken | input | 1 | Actual direction of the reported branch |
| res_target | input | 32 | Actual target of the reported branch |
| next_addr | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | Current fetch predicted taken with a cached target |
| alloc_tag | output | 2 | Tag given to a branch allocated this cycle |
| stall | output | 1 | Four tags live, dispatch must hold |
| rec_complete | output | 1 | Recovery step: complete through the branch |
| rec_flush | output | 1 | Recovery step: flush and refetch |
| rec_dispatch | output | 1 | Recovery step: re-dispatch |
| rec_execute | output | 1 | Recovery step: re-execute |
| redirect_addr | output | 32 | Corrected fetch address, valid with rec_flush |

## Verification
Assertions check the following on every cycle:
- the step outputs are mutually exclusive, and the flush step is followed by the dispatch step;
- a misprediction always leads to the complete step next cycle;
- an allocated tag becomes live;
- the live set cannot change while all four tags are live and no report arrives;
- a mispredicted tag is dead one cycle later;
- a correct report frees exactly one tag;
- a counter at its taken limit stays there;
- a taken report leaves a valid target entry.

Other behaviours need constructed histories, and only the bench scenarios can show them. These are:
- the age order of tag release after out-of-order frees;
- the restart of recovery by an older branch;
- the target cache entry being cleared on a not-taken hit;
- reports on dead tags being ignored;
- predictions matching a reference table model under random training.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_COMPLETE,
        RS_FLUSH,
        RS_DISPATCH,
        RS_EXECUTE
    } rec_state_t;

    function automatic logic [1:0] sat_step(input logic [1:0] cur, input logic up);
        logic [1:0] res;
        if (up) res = (cur == 2'b11) ? cur : cur + 2'b01;
        else    res = (cur == 2'b00) ? cur : cur - 2'b01;
        return res;
    endfunction

endpackage

// File: rtl/bsu_dir_table.sv
module bsu_dir_table #(
    parameter int ENTRIES = 2048,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);
    import bsu_pkg::*;

    logic [1:0] ctr [ENTRIES];

    assign rd_taken = ctr[rd_idx][1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ctr[i] <= 2'b01;
        end else if (upd_en) begin
            ctr[upd_idx] <= sat_step(ctr[upd_idx], upd_taken);
        end
    end

    // R2: saturation at the taken limit
    assert_ctr_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken && ctr[upd_idx] == 2'b11) |=> (ctr[$past(upd_idx)] == 2'b11))
        else $error("counter left taken limit");

endmodule

// File: rtl/bsu_target_cache.sv
module bsu_target_cache #(
    parameter int ENTRIES = 256,
    parameter int TAG_W   = 8,
    parameter int AW      = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [AW-1:0]    rd_target,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic             upd_taken,
    input  logic [AW-1:0]    upd_target
);
    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_mem [ENTRIES];
    logic [AW-1:0]      tgt_mem [ENTRIES];
    logic               upd_hit;

    assign rd_hit    = vld_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);
    assign rd_target = tgt_mem[rd_idx];
    assign upd_hit   = vld_q[upd_idx] && (tag_mem[upd_idx] == upd_tag);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (upd_en) begin
            if (upd_taken)    vld_q[upd_idx] <= 1'b1;
            else if (upd_hit) vld_q[upd_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (upd_en && upd_taken) begin
            tag_mem[upd_idx] <= upd_tag;
            tgt_mem[upd_idx] <= upd_target;
        end
    end

    // R5: taken training leaves a valid entry
    assert_write_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_taken) |=> vld_q[$past(upd_idx)])
        else $error("target entry not valid after taken update");

endmodule

// File: rtl/bsu_tag_tracker.sv
module bsu_tag_tracker #(
    parameter int SLOTS = 4,
    parameter int AW    = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic [AW-1:0]     alloc_pc,
    input  logic              alloc_pred_taken,
    input  logic [AW-1:0]     alloc_pred_tgt,
    output logic [SLOT_W-1:0] alloc_tag,
    output logic              full,
    input  logic              res_valid,
    input  logic [SLOT_W-1:0] res_tag,
    input  logic              res_taken,
    input  logic [AW-1:0]     res_target,
    output logic              res_ok,
    output logic              res_mispred,
    output logic [AW-1:0]     res_pc,
    output logic [AW-1:0]     res_fix_addr
);
    logic [SLOTS-1:0] valid_q;
    logic [SLOTS-1:0] ahead_q [SLOTS];
    logic [AW-1:0]    pc_mem   [SLOTS];
    logic [AW-1:0]    ptgt_mem [SLOTS];
    logic [SLOTS-1:0] ptk_q;
    logic [SLOTS-1:0] kill, alloc_vec, valid_nx;
    logic             alloc_fire;

    assign full   = &valid_q;
    assign res_ok = res_valid && valid_q[res_tag];
    assign res_pc = pc_mem[res_tag];
    assign res_mispred = res_ok && ((ptk_q[res_tag] != res_taken) ||
                         (res_taken && (ptgt_mem[res_tag] != res_target)));
    assign res_fix_addr = res_taken ? res_target : res_pc + AW'(4);
    assign alloc_fire = alloc_req && !full && !res_mispred;

    always_comb begin
        alloc_tag = '0;
        for (int i = SLOTS - 1; i >= 0; i--)
            if (!valid_q[i]) alloc_tag = SLOT_W'(i);
    end

    always_comb begin
        kill = '0;
        if (res_ok) begin
            kill[res_tag] = 1'b1;
            if (res_mispred)
                for (int j = 0; j < SLOTS; j++)
                    if (valid_q[j] && ahead_q[j][res_tag]) kill[j] = 1'b1;
        end
    end

    assign alloc_vec = alloc_fire ? (SLOTS'(1) << alloc_tag) : '0;
    assign valid_nx  = (valid_q & ~kill) | alloc_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < SLOTS; i++) ahead_q[i] <= '0;
        end else begin
            valid_q <= valid_nx;
            if (alloc_fire) begin
                for (int i = 0; i < SLOTS; i++) begin
                    if (alloc_tag == SLOT_W'(i)) ahead_q[i] <= valid_q & ~kill;
                    else                         ahead_q[i][alloc_tag] <= 1'b0;
                end
            end
        end
    end

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (alloc_fire && alloc_tag == SLOT_W'(s)) begin
                    pc_mem[s]   <= alloc_pc;
                    ptgt_mem[s] <= alloc_pred_tgt;
                    ptk_q[s]    <= alloc_pred_taken;
                end
            end
        end
    endgenerate

    // R6: a granted tag is live next cycle
    assert_alloc_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |=> valid_q[$past(alloc_tag)])
        else $error("allocated tag not live");

    // R7: a full tracker does not change without a report
    assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !res_ok) |=> $stable(valid_q))
        else $error("live set changed while full");

    // R9: a mispredicted tag is released
    assert_mispred_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_mispred |=> !valid_q[$past(res_tag)])
        else $error("mispredicted tag still live");

    // R8: a correct report frees exactly one tag
    assert_correct_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_ok && !res_mispred && !alloc_fire) |=>
        ($countones(valid_q) + 1 == $countones($past(valid_q))))
        else $error("correct report freed wrong count");

endmodule

// File: rtl/bsu_recovery_fsm.sv
module bsu_recovery_fsm #(
    parameter int AW              = 32,
    parameter int COMPLETE_CYCLES = 1,
    localparam int CW = $clog2(COMPLETE_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mispred,
    input  logic [AW-1:0] fix_addr,
    output logic          busy,
    output logic          rec_complete,
    output logic          rec_flush,
    output logic          rec_dispatch,
    output logic          rec_execute,
    output logic [AW-1:0] redirect_addr
);
    import bsu_pkg::*;

    rec_state_t    state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic [AW-1:0] fix_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RS_IDLE;
            cnt   <= '0;
            fix_q <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            if (mispred) fix_q <= fix_addr;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (mispred) begin
            state_nx = RS_COMPLETE;
            cnt_nx   = '0;
        end else begin
            unique case (state)
                RS_IDLE:     state_nx = RS_IDLE;
                RS_COMPLETE: begin
                    if (cnt == CW'(COMPLETE_CYCLES - 1)) state_nx = RS_FLUSH;
                    else                                 cnt_nx   = cnt + CW'(1);
                end
                RS_FLUSH:    state_nx = RS_DISPATCH;
                RS_DISPATCH: state_nx = RS_EXECUTE;
                RS_EXECUTE:  state_nx = RS_IDLE;
                default:     state_nx = RS_IDLE;
            endcase
        end
    end

    always_comb begin
        rec_complete  = 1'b0;
        rec_flush     = 1'b0;
        rec_dispatch  = 1'b0;
        rec_execute   = 1'b0;
        busy          = 1'b1;
        redirect_addr = fix_q;
        unique case (state)
            RS_IDLE:     busy         = 1'b0;
            RS_COMPLETE: rec_complete = 1'b1;
            RS_FLUSH:    rec_flush    = 1'b1;
            RS_DISPATCH: rec_dispatch = 1'b1;
            RS_EXECUTE:  rec_execute  = 1'b1;
            default:     busy         = 1'b0;
        endcase
    end

    // R10: step outputs never overlap
    assert_step_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rec_complete, rec_flush, rec_dispatch, rec_execute}))
        else $error("recovery steps overlap");

    // R10: flush is followed by dispatch
    assert_flush_then_dispatch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_flush && !mispred) |=> rec_dispatch)
        else $error("dispatch step did not follow flush");

    // R12: any misprediction (re)starts the complete step
    assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mispred |=> rec_complete)
        else $error("misprediction did not enter complete step");

endmodule

// File: rtl/branch_spec_unit.sv
module branch_spec_unit #(
    parameter int AW              = 32,
    parameter int DIR_ENTRIES     = 2048,
    parameter int TGT_ENTRIES     = 256,
    parameter int TGT_TAG_W       = 8,
    parameter int SLOTS           = 4,
    parameter int COMPLETE_CYCLES = 1,
    localparam int DIR_IDX_W = $clog2(DIR_ENTRIES),
    localparam int TGT_IDX_W = $clog2(TGT_ENTRIES),
    localparam int SLOT_W    = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [AW-1:0]     fetch_addr,
    input  logic              br_decoded,
    input  logic              res_valid,
    input  logic [SLOT_W-1:0] res_tag,
    input  logic              res_taken,
    input  logic [AW-1:0]     res_target,
    output logic [AW-1:0]     next_addr,
    output logic              pred_taken,
    output logic [SLOT_W-1:0] alloc_tag,
    output logic              stall,
    output logic              rec_complete,
    output logic              rec_flush,
    output logic              rec_dispatch,
    output logic              rec_execute,
    output logic [AW-1:0]     redirect_addr
);
    logic          dir_taken, tgt_hit, busy;
    logic [AW-1:0] tgt_addr, res_pc, fix_addr;
    logic          res_ok, res_mispred;

    bsu_dir_table #(.ENTRIES(DIR_ENTRIES)) u_dir (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(fetch_addr[2 +: DIR_IDX_W]), .rd_taken(dir_taken),
        .upd_en(res_ok), .upd_idx(res_pc[2 +: DIR_IDX_W]), .upd_taken(res_taken)
    );

    bsu_target_cache #(.ENTRIES(TGT_ENTRIES), .TAG_W(TGT_TAG_W), .AW(AW)) u_tgt (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(fetch_addr[2 +: TGT_IDX_W]),
        .rd_tag(fetch_addr[2 + TGT_IDX_W +: TGT_TAG_W]),
        .rd_hit(tgt_hit), .rd_target(tgt_addr),
        .upd_en(res_ok), .upd_idx(res_pc[2 +: TGT_IDX_W]),
        .upd_tag(res_pc[2 + TGT_IDX_W +: TGT_TAG_W]),
        .upd_taken(res_taken), .upd_target(res_target)
    );

    assign pred_taken = fetch_valid && dir_taken && tgt_hit;
    assign next_addr  = pred_taken ? tgt_addr : fetch_addr + AW'(4);

    bsu_tag_tracker #(.SLOTS(SLOTS), .AW(AW)) u_trk (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(fetch_valid && br_decoded && !busy),
        .alloc_pc(fetch_addr), .alloc_pred_taken(pred_taken), .alloc_pred_tgt(next_addr),
        .alloc_tag(alloc_tag), .full(stall),
        .res_valid(res_valid), .res_tag(res_tag), .res_taken(res_taken),
        .res_target(res_target), .res_ok(res_ok), .res_mispred(res_mispred),
        .res_pc(res_pc), .res_fix_addr(fix_addr)
    );

    bsu_recovery_fsm #(.AW(AW), .COMPLETE_CYCLES(COMPLETE_CYCLES)) u_rec (
        .clk(clk), .rst_n(rst_n),
        .mispred(res_mispred), .fix_addr(fix_addr), .busy(busy),
        .rec_complete(rec_complete), .rec_flush(rec_flush),
        .rec_dispatch(rec_dispatch), .rec_execute(rec_execute),
        .redirect_addr(redirect_addr)
    );

endmodule

// File: tb/branch_spec_unit_tb.sv
`timescale 1ns/1ps
module branch_spec_unit_tb;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        fetch_valid, br_decoded, res_valid, res_taken;
    logic [31:0] fetch_addr, res_target;
    logic [1:0]  res_tag;
    logic [31:0] next_addr, redirect_addr;
    logic        pred_taken, stall, rec_complete, rec_flush, rec_dispatch, rec_execute;
    logic [1:0]  alloc_tag;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench reference model
    int          m_ctr [2048];
    bit          m_bv  [256];
    logic [7:0]  m_btag [256];
    logic [31:0] m_btgt [256];
    logic [31:0] s_pc [4];
    bit          s_pt [4];
    logic [31:0] s_tgt [4];

    branch_spec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .br_decoded(br_decoded), .res_valid(res_valid), .res_tag(res_tag),
        .res_taken(res_taken), .res_target(res_target), .next_addr(next_addr),
        .pred_taken(pred_taken), .alloc_tag(alloc_tag), .stall(stall),
        .rec_complete(rec_complete), .rec_flush(rec_flush), .rec_dispatch(rec_dispatch),
        .rec_execute(rec_execute), .redirect_addr(redirect_addr)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        fetch_valid = 0; br_decoded = 0; fetch_addr = '0;
        res_valid = 0; res_tag = '0; res_taken = 0; res_target = '0;
    endtask

    function automatic void predict(input logic [31:0] a, output bit pt, output logic [31:0] nx);
        int  di = int'(a[12:2]);
        int  ti = int'(a[9:2]);
        bit  hit = m_bv[ti] && (m_btag[ti] == a[17:10]);
        pt = (m_ctr[di] >= 2) && hit;
        nx = pt ? m_btgt[ti] : a + 32'd4;
    endfunction

    function automatic void train(input logic [31:0] a, input bit tk, input logic [31:0] tg);
        int di = int'(a[12:2]);
        int ti = int'(a[9:2]);
        if (tk && m_ctr[di] < 3) m_ctr[di]++;
        if (!tk && m_ctr[di] > 0) m_ctr[di]--;
        if (tk) begin
            m_bv[ti] = 1; m_btag[ti] = a[17:10]; m_btgt[ti] = tg;
        end else if (m_bv[ti] && m_btag[ti] == a[17:10]) begin
            m_bv[ti] = 0;
        end
    endfunction

    // checks prediction (R4) and given tag (R6), then allocates
    task automatic alloc_br(input logic [31:0] a, input logic [1:0] exp_tag);
        bit pt; logic [31:0] nx;
        fetch_valid = 1; br_decoded = 1; fetch_addr = a;
        #1;
        predict(a, pt, nx);
        chk(next_addr == nx, "R4 next_addr", next_addr, nx);
        chk(pred_taken == pt, "R4 pred_taken", {31'd0, pred_taken}, {31'd0, pt});
        chk(alloc_tag == exp_tag, "R6 alloc_tag", {30'd0, alloc_tag}, {30'd0, exp_tag});
        s_pc[exp_tag] = a; s_pt[exp_tag] = pt; s_tgt[exp_tag] = nx;
        step();
        fetch_valid = 0; br_decoded = 0;
    endtask

    task automatic report(input logic [1:0] t, input bit tk, input logic [31:0] tg,
                          input bit live, output bit mis, output logic [31:0] fix);
        res_valid = 1; res_tag = t; res_taken = tk; res_target = tg;
        mis = live && ((s_pt[t] != tk) || (tk && s_tgt[t] != tg));
        fix = tk ? tg : s_pc[t] + 32'd4;
        if (live) train(s_pc[t], tk, tg);
        step();
        res_valid = 0;
    endtask

    task automatic expect_recovery(input logic [31:0] fix, input string req);
        chk(rec_complete == 1, {req, " complete step"}, {31'd0, rec_complete}, 32'd1);
        step();
        chk(rec_flush == 1, {req, " flush step"}, {31'd0, rec_flush}, 32'd1);
        chk(redirect_addr == fix, {req, " redirect_addr"}, redirect_addr, fix);
        step();
        chk(rec_dispatch == 1, {req, " dispatch step"}, {31'd0, rec_dispatch}, 32'd1);
        step();
        chk(rec_execute == 1, {req, " execute step"}, {31'd0, rec_execute}, 32'd1);
        step();
        chk({rec_complete, rec_flush, rec_dispatch, rec_execute} == 4'b0, {req, " back to idle"},
            {28'd0, rec_complete, rec_flush, rec_dispatch, rec_execute}, 32'd0);
    endtask

    task automatic see_next(input logic [31:0] a, input logic [31:0] exp, input string req);
        fetch_valid = 1; fetch_addr = a; #1;
        chk(next_addr == exp, req, next_addr, exp);
        fetch_valid = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        bit mis; logic [31:0] fix; logic [31:0] pc;
        void'($urandom(32'd1994));
        for (int i = 0; i < 2048; i++) m_ctr[i] = 1;
        for (int i = 0; i < 256; i++) m_bv[i] = 0;
        idle_in();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state
        chk(stall == 0, "R1 stall", {31'd0, stall}, 32'd0);
        chk({rec_complete, rec_flush, rec_dispatch, rec_execute} == 4'b0, "R1 steps idle",
            {28'd0, rec_complete, rec_flush, rec_dispatch, rec_execute}, 32'd0);
        fetch_valid = 1; fetch_addr = 32'h100; #1;
        chk(next_addr == 32'h104, "R1 sequential next", next_addr, 32'h104);
        chk(pred_taken == 0, "R1 pred_taken", {31'd0, pred_taken}, 32'd0);
        chk(alloc_tag == 0, "R1 alloc_tag", {30'd0, alloc_tag}, 32'd0);
        fetch_valid = 0;

        // R6 / R7 fill the tracker
        pc = 32'h4000;
        for (int k = 0; k < 4; k++) begin alloc_br(pc, 2'(k)); pc += 16; end
        chk(stall == 1, "R7 stall at four", {31'd0, stall}, 32'd1);
        fetch_valid = 1; br_decoded = 1; fetch_addr = pc; step(); idle_in();
        chk(stall == 1, "R7 fifth branch held", {31'd0, stall}, 32'd1);

        // R8 correct report frees only its tag
        report(2'd2, 0, 32'h0, 1, mis, fix);
        chk(stall == 0, "R8 stall released", {31'd0, stall}, 32'd0);
        chk(alloc_tag == 2, "R8 only own tag freed", {30'd0, alloc_tag}, 32'd2);
        chk(rec_complete == 0, "R8 no recovery", {31'd0, rec_complete}, 32'd0);
        alloc_br(pc, 2'd2); pc += 16;
        chk(stall == 1, "R7 full again", {31'd0, stall}, 32'd1);

        // R9 mispredict tag 1: frees 1, 3, 2 (younger), keeps 0
        report(2'd1, 1, 32'h9000, 1, mis, fix);
        expect_recovery(32'h9000, "R10");
        chk(alloc_tag == 1, "R9 lowest free after flush", {30'd0, alloc_tag}, 32'd1);
        chk(stall == 0, "R9 stall cleared", {31'd0, stall}, 32'd0);
        for (int k = 1; k < 4; k++) begin alloc_br(pc, 2'(k)); pc += 16; end
        chk(stall == 1, "R9 older tag survived", {31'd0, stall}, 32'd1);

        // R9 mispredict oldest clears all
        report(2'd0, 1, 32'h9100, 1, mis, fix);
        expect_recovery(32'h9100, "R9");
        for (int k = 0; k < 4; k++) begin alloc_br(pc, 2'(k)); pc += 16; end
        chk(stall == 1, "R9 all four reusable", {31'd0, stall}, 32'd1);
        report(2'd0, 1, 32'h9200, 1, mis, fix);
        expect_recovery(32'h9200, "R9");

        // R5 write, R11 ignored report, R5 clear
        pc = 32'h5000;
        alloc_br(pc, 2'd0);
        report(2'd0, 1, 32'hA000, 1, mis, fix);
        expect_recovery(32'hA000, "R10");
        alloc_br(pc, 2'd0);
        report(2'd0, 1, 32'hA000, 1, mis, fix);
        chk(mis == 0 && rec_complete == 0, "R2 taken prediction correct",
            {31'd0, rec_complete}, 32'd0);
        see_next(pc, 32'hA000, "R5 entry written");
        report(2'd0, 0, 32'h0, 0, mis, fix);
        chk(rec_complete == 0, "R11 dead tag no recovery", {31'd0, rec_complete}, 32'd0);
        see_next(pc, 32'hA000, "R11 tables untouched");
        chk(alloc_tag == 0, "R11 no tag change", {30'd0, alloc_tag}, 32'd0);
        alloc_br(pc, 2'd0);
        report(2'd0, 0, 32'h0, 1, mis, fix);
        expect_recovery(pc + 32'd4, "R10 not-taken fix");
        see_next(pc, pc + 32'd4, "R5 entry cleared on not-taken hit");

        // R12 restart during recovery, no allocation while busy
        alloc_br(32'h6000, 2'd0);
        alloc_br(32'h6010, 2'd1);
        report(2'd1, 1, 32'hB000, 1, mis, fix);
        chk(rec_complete == 1, "R12 first complete", {31'd0, rec_complete}, 32'd1);
        res_valid = 1; res_tag = 2'd0; res_taken = 1; res_target = 32'hB100;
        train(32'h6000, 1, 32'hB100);
        step(); res_valid = 0;
        chk(rec_complete == 1 && rec_flush == 0, "R12 restart at complete",
            {30'd0, rec_complete, rec_flush}, 32'd2);
        step();
        chk(rec_flush == 1 && redirect_addr == 32'hB100, "R12 new redirect", redirect_addr, 32'hB100);
        fetch_valid = 1; br_decoded = 1; fetch_addr = 32'h6100;
        step(); step(); idle_in();
        step();
        chk(alloc_tag == 0, "R12 no allocation while busy", {30'd0, alloc_tag}, 32'd0);
        chk(stall == 0, "R12 tracker empty", {31'd0, stall}, 32'd0);

        // random training against the reference model (R2 R3 R4 R5 R10)
        for (int it = 0; it < 400; it++) begin
            logic [31:0] a, tg;
            bit tk;
            int sel = int'($urandom_range(0, 9));
            a  = (sel == 9) ? 32'h1400 : 32'h1000 + 32'(sel) * 32'd4;
            tg = 32'h8000 + 32'($urandom_range(0, 3)) * 32'd4;
            tk = ($urandom_range(0, 3) != 0);
            alloc_br(a, 2'd0);
            report(2'd0, tk, tg, 1, mis, fix);
            if (mis) expect_recovery(fix, "R10 random");
            else chk(rec_complete == 0, "R8 random correct", {31'd0, rec_complete}, 32'd0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule